// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Logic

This block produces one interrupt line for each side of a two-port shared memory. Each port owns one mailbox word at the top of the address space. The right port owns the highest address (all ones). The left port owns the address one below it (all ones except bit 0). When a port writes into the mailbox owned by the opposite port, that opposite port's interrupt line goes low. The interrupt stays low until the owning port reads its own mailbox. The message stored in each mailbox is ordinary memory content, defined by software, and the block does not hold it.

Each port presents its active-low chip enable, write strobe and output enable, its address, and an active-low busy indication from the collision arbiter. While a port's busy input is low, any set or clear that the port's access would cause is suppressed. The flags are registered on the clock and reset asynchronously. The address width is a parameter, and both mailbox addresses are derived from it.

Top module: `mbox_irq`

## Requirements
- R1: While reset is asserted, and after reset is released, both interrupt outputs are high (deasserted) until a set occurs.
- R2: A right-port write (chip enable low, write strobe low, busy high) to address all-ones-except-bit-0 drives the left interrupt low after the next rising clock edge.
- R3: A left-port write (chip enable low, write strobe low, busy high) to address all-ones drives the right interrupt low after the next rising clock edge.
- R4: A left-port access to address all-ones-except-bit-0 with chip enable and output enable both low and busy high returns the left interrupt high after the next edge. The write strobe value does not matter for this clear.
- R5: A right-port access to address all-ones with chip enable and output enable both low and busy high returns the right interrupt high after the next edge. The write strobe value does not matter for this clear.
- R6: A write is recognised only when chip enable and write strobe are both low. With either input high, no interrupt is set.
- R7: While the acting port's busy input is low, its set or clear action leaves the affected interrupt unchanged.
- R8: If a set and a clear reach the same interrupt in one cycle, the set wins and the output goes or stays low.
- R9: Accesses to any address other than the two mailbox addresses leave both interrupts unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| l_ce_ni | input | 1 | Left chip enable, active low |
| l_we_ni | input | 1 | Left write strobe, active low |
| l_oe_ni | input | 1 | Left output enable, active low |
| l_addr_i | input | AW | Left address |
| l_busy_ni | input | 1 | Left busy indication, active low |
| r_ce_ni | input | 1 | Right chip enable, active low |
| r_we_ni | input | 1 | Right write strobe, active low |
| r_oe_ni | input | 1 | Right output enable, active low |
| r_addr_i | input | AW | Right address |
| r_busy_ni | input | 1 | Right busy indication, active low |
| l_irq_no | output | 1 | Left interrupt, active low |
| r_irq_no | output | 1 | Right interrupt, active low |

## Verification
Each interrupt output reflects the inputs sampled at one rising edge. It is due exactly one edge after the stimulus, with no further latency for either sets or clears. The bench changes inputs on the falling edge and compares both outputs on the following falling edge, half a period after the capturing edge. Its reference model advances the expected flags once per driven cycle, so every comparison matches the stimulus of the preceding cycle.

// File: rtl/mbox_irq_pkg.sv
package mbox_irq_pkg;
  typedef enum int unsigned {
    PORT_L = 0,
    PORT_R = 1
  } port_e;

  localparam int unsigned NUM_PORTS = 2;

  function automatic int unsigned peer_of(int unsigned p);
    return (p == PORT_L) ? PORT_R : PORT_L;
  endfunction
endpackage

// File: rtl/mbox_decode.sv
module mbox_decode #(
  parameter int unsigned    AW        = 14,
  parameter logic [AW-1:0]  OWN_ADDR  = '1,
  parameter logic [AW-1:0]  PEER_ADDR = '1
) (
  input  logic          ce_ni,
  input  logic          we_ni,
  input  logic          oe_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          busy_ni,
  output logic          peer_set_o,
  output logic          own_clr_o
);
  logic wr_act, rd_act;

  assign wr_act = ~ce_ni & ~we_ni;
  // clear ignores the write strobe
  assign rd_act = ~ce_ni & ~oe_ni;

  assign peer_set_o = wr_act & busy_ni & (addr_i == PEER_ADDR);
  assign own_clr_o  = rd_act & busy_ni & (addr_i == OWN_ADDR);
endmodule

// File: rtl/mbox_flag.sv
module mbox_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_no
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pend_q <= 1'b0;
    else if (set_i) pend_q <= 1'b1;
    else if (clr_i) pend_q <= 1'b0;
  end

  assign irq_no = ~pend_q;
endmodule

// File: rtl/mbox_irq.sv
module mbox_irq
  import mbox_irq_pkg::*;
#(
  parameter int unsigned AW = 14
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          l_ce_ni,
  input  logic          l_we_ni,
  input  logic          l_oe_ni,
  input  logic [AW-1:0] l_addr_i,
  input  logic          l_busy_ni,
  input  logic          r_ce_ni,
  input  logic          r_we_ni,
  input  logic          r_oe_ni,
  input  logic [AW-1:0] r_addr_i,
  input  logic          r_busy_ni,
  output logic          l_irq_no,
  output logic          r_irq_no
);
  localparam logic [AW-1:0] MBOX_R = {AW{1'b1}};
  localparam logic [AW-1:0] MBOX_L = MBOX_R - 1'b1;

  logic [NUM_PORTS-1:0]         ce_n, we_n, oe_n, busy_n;
  logic [NUM_PORTS-1:0][AW-1:0] addr;
  logic [NUM_PORTS-1:0]         peer_set, own_clr, irq_n;

  assign ce_n[PORT_L]   = l_ce_ni;
  assign ce_n[PORT_R]   = r_ce_ni;
  assign we_n[PORT_L]   = l_we_ni;
  assign we_n[PORT_R]   = r_we_ni;
  assign oe_n[PORT_L]   = l_oe_ni;
  assign oe_n[PORT_R]   = r_oe_ni;
  assign addr[PORT_L]   = l_addr_i;
  assign addr[PORT_R]   = r_addr_i;
  assign busy_n[PORT_L] = l_busy_ni;
  assign busy_n[PORT_R] = r_busy_ni;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    localparam logic [AW-1:0] OWN  = (p == PORT_R) ? MBOX_R : MBOX_L;
    localparam logic [AW-1:0] PEER = (p == PORT_R) ? MBOX_L : MBOX_R;

    mbox_decode #(
      .AW       (AW),
      .OWN_ADDR (OWN),
      .PEER_ADDR(PEER)
    ) u_dec (
      .ce_ni     (ce_n[p]),
      .we_ni     (we_n[p]),
      .oe_ni     (oe_n[p]),
      .addr_i    (addr[p]),
      .busy_ni   (busy_n[p]),
      .peer_set_o(peer_set[p]),
      .own_clr_o (own_clr[p])
    );

    // a port's flag is set by the opposite port, cleared by itself
    mbox_flag u_flag (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (peer_set[peer_of(p)]),
      .clr_i (own_clr[p]),
      .irq_no(irq_n[p])
    );
  end

  assign l_irq_no = irq_n[PORT_L];
  assign r_irq_no = irq_n[PORT_R];
endmodule

// File: rtl/mbox_irq_chk.sv
module mbox_irq_chk #(
  parameter int unsigned AW = 14
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          l_ce_ni,
  input logic          l_we_ni,
  input logic          l_oe_ni,
  input logic [AW-1:0] l_addr_i,
  input logic          l_busy_ni,
  input logic          r_ce_ni,
  input logic          r_we_ni,
  input logic          r_oe_ni,
  input logic [AW-1:0] r_addr_i,
  input logic          r_busy_ni,
  input logic          l_irq_no,
  input logic          r_irq_no
);
  localparam logic [AW-1:0] TOP  = {AW{1'b1}};
  localparam logic [AW-1:0] NEXT = TOP - 1'b1;

  logic set_l, set_r, clr_l, clr_r;
  assign set_l = !r_ce_ni && !r_we_ni && r_busy_ni && (r_addr_i == NEXT);
  assign set_r = !l_ce_ni && !l_we_ni && l_busy_ni && (l_addr_i == TOP);
  assign clr_l = !l_ce_ni && !l_oe_ni && l_busy_ni && (l_addr_i == NEXT);
  assign clr_r = !r_ce_ni && !r_oe_ni && r_busy_ni && (r_addr_i == TOP);

  always @(posedge clk_i)
    if (!rst_ni) assert_reset_high_R1: assert (l_irq_no && r_irq_no);

  assert_left_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_l |=> !l_irq_no);
  assert_right_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_r |=> !r_irq_no);
  assert_left_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_l && !set_l) |=> l_irq_no);
  assert_right_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_r && !set_r) |=> r_irq_no);
  assert_no_write_no_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((r_ce_ni || r_we_ni) && l_irq_no && !clr_l) |=> l_irq_no);
  assert_busy_blocks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!r_busy_ni && !clr_l) |=> $stable(l_irq_no));
  assert_busy_blocks_clr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!r_busy_ni && !set_r) |=> $stable(r_irq_no));
  assert_set_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_r && clr_r) |=> !r_irq_no);
  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_l && !clr_l && !set_r && !clr_r) |=> ($stable(l_irq_no) && $stable(r_irq_no)));
endmodule

bind mbox_irq mbox_irq_chk #(.AW(AW)) u_chk (.*);

// File: tb/mbox_irq_tb.sv
module mbox_irq_tb;
  localparam int unsigned AW = 14;
  localparam logic [AW-1:0] TOP  = {AW{1'b1}};
  localparam logic [AW-1:0] NEXT = TOP - 1'b1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic l_ce_n, l_we_n, l_oe_n, l_busy_n, r_ce_n, r_we_n, r_oe_n, r_busy_n;
  logic [AW-1:0] l_addr, r_addr;
  logic l_irq_n, r_irq_n;
  logic exp_l = 1'b0, exp_r = 1'b0; // pending flags, 1 = interrupt low
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mbox_irq #(.AW(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .l_ce_ni(l_ce_n), .l_we_ni(l_we_n), .l_oe_ni(l_oe_n), .l_addr_i(l_addr), .l_busy_ni(l_busy_n),
    .r_ce_ni(r_ce_n), .r_we_ni(r_we_n), .r_oe_ni(r_oe_n), .r_addr_i(r_addr), .r_busy_ni(r_busy_n),
    .l_irq_no(l_irq_n), .r_irq_no(r_irq_n)
  );

  function automatic logic next_flag(logic cur, logic set, logic clr);
    return set ? 1'b1 : (clr ? 1'b0 : cur);
  endfunction

  task automatic idle();
    l_ce_n = 1; l_we_n = 1; l_oe_n = 1; l_addr = '0; l_busy_n = 1;
    r_ce_n = 1; r_we_n = 1; r_oe_n = 1; r_addr = '0; r_busy_n = 1;
  endtask

  // inputs are set; update model, cross the capturing edge, land on falling edge
  task automatic step();
    logic sl, sr, cl, cr;
    sl = !r_ce_n && !r_we_n && r_busy_n && (r_addr == NEXT);
    sr = !l_ce_n && !l_we_n && l_busy_n && (l_addr == TOP);
    cl = !l_ce_n && !l_oe_n && l_busy_n && (l_addr == NEXT);
    cr = !r_ce_n && !r_oe_n && r_busy_n && (r_addr == TOP);
    exp_l = next_flag(exp_l, sl, cl);
    exp_r = next_flag(exp_r, sr, cr);
    @(posedge clk); @(negedge clk);
  endtask

  task automatic check(string tag, logic el, logic er);
    checks++;
    if (l_irq_n !== el || r_irq_n !== er) begin
      fails++;
      $display("FAIL %s: l_irq=%b r_irq=%b expected l_irq=%b r_irq=%b", tag, l_irq_n, r_irq_n, el, er);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    idle();
    #5;
    check("R1 in reset", 1, 1);
    @(negedge clk); rst_n = 1; @(negedge clk);
    check("R1 after reset", 1, 1);

    r_ce_n = 0; r_we_n = 0; r_addr = NEXT; step(); idle();
    check("R2 right writes left mailbox", 0, 1);
    l_ce_n = 0; l_oe_n = 0; l_we_n = 0; l_addr = NEXT; step(); idle();
    check("R4 left clears with strobe low", 1, 1);
    l_ce_n = 0; l_we_n = 0; l_addr = TOP; step(); idle();
    check("R3 left writes right mailbox", 1, 0);
    r_ce_n = 0; r_oe_n = 0; r_addr = TOP; step(); idle();
    check("R5 right clears", 1, 1);

    r_ce_n = 1; r_we_n = 0; r_addr = NEXT; step(); idle();
    check("R6 ce high no set", 1, 1);
    r_ce_n = 0; r_we_n = 1; r_addr = NEXT; step(); idle();
    check("R6 strobe high no set", 1, 1);

    r_ce_n = 0; r_we_n = 0; r_addr = NEXT; r_busy_n = 0; step(); idle();
    check("R7 busy blocks set", 1, 1);
    r_ce_n = 0; r_we_n = 0; r_addr = NEXT; step(); idle();
    l_ce_n = 0; l_oe_n = 0; l_addr = NEXT; l_busy_n = 0; step(); idle();
    check("R7 busy blocks clear", 0, 1);
    l_ce_n = 0; l_oe_n = 0; l_addr = NEXT; step(); idle();
    check("R4 clear again", 1, 1);

    r_ce_n = 0; r_we_n = 0; r_addr = NEXT; l_ce_n = 0; l_oe_n = 0; l_addr = NEXT; step(); idle();
    check("R8 set beats clear", 0, 1);

    r_ce_n = 0; r_we_n = 0; r_addr = NEXT - 1'b1; l_ce_n = 0; l_oe_n = 0; l_addr = NEXT - 1'b1; step(); idle();
    check("R9 other address holds", 0, 1);
    l_ce_n = 0; l_we_n = 0; l_addr = '0; r_ce_n = 0; r_oe_n = 0; r_addr = TOP - 2'd3; step(); idle();
    check("R9 low address no set", 0, 1);

    for (int i = 0; i < 3000; i++) begin
      logic [AW-1:0] a;
      int unsigned sel;
      l_ce_n = $urandom_range(0, 1); l_we_n = $urandom_range(0, 1); l_oe_n = $urandom_range(0, 1);
      r_ce_n = $urandom_range(0, 1); r_we_n = $urandom_range(0, 1); r_oe_n = $urandom_range(0, 1);
      l_busy_n = ($urandom_range(0, 5) != 0); r_busy_n = ($urandom_range(0, 5) != 0);
      sel = $urandom_range(0, 2); a = AW'($urandom);
      l_addr = (sel == 0) ? TOP : (sel == 1) ? NEXT : a;
      sel = $urandom_range(0, 2); a = AW'($urandom);
      r_addr = (sel == 0) ? TOP : (sel == 1) ? NEXT : a;
      step();
      check("R2 R3 R4 R5 R6 R7 R8 R9 random", !exp_l, !exp_r);
    end
    finish_run();
  end

  initial void'($urandom(32'h1d5e));
endmodule